// File: doc/BRIEF.md
# Intel HEX Record Parser

This block takes a stream of ASCII characters, one per cycle while `in_valid` is high, holding Intel HEX records. It decodes each record's byte count, 16-bit load offset and record type. It keeps a running 8-bit checksum as the characters arrive. Payload bytes of data records go out one per strobe, each with its own address. Extended-address records (type 04) are consumed without any output. An end-of-file record halts the parser until the next reset.

Malformed input raises a one-cycle error pulse with a kind code. The kinds are: a bad character, a checksum mismatch, or an unsupported record type. After a bad character the parser resynchronises on the next colon. The block stores no data; a downstream writer uses the address/data strobe directly.

Top module: `hex_record_parser`

## Requirements
- R1: After synchronous reset, `out_valid`, `eof`, `done` and `err` are all low.
- R2: Inside a record, each byte is two hex characters, high nibble first. Digits 0-9, A-F and a-f are all accepted.
- R3: Each payload byte of a type 00 record appears on `out_data` with `out_valid` high. This happens in the cycle after the byte's second character is accepted. `out_addr` equals the load offset plus the byte's index in the record.
- R4: The address computation wraps modulo 2^16.
- R5: The checksum is checked after the record's last character. The length, both offset bytes, the type, the data bytes and the checksum byte must sum to 0x00 (mod 256). On a mismatch, `err` pulses one cycle later with `err_kind` = 2.
- R6: A type 04 record with a correct checksum produces no `out_valid` and no `err`.
- R7: A type 01 record with a correct checksum pulses `eof` and raises `done`. `done` stays high, and all later input produces no `out_valid`, `eof` or `err`.
- R8: Between records, carriage return (0x0D) and line feed (0x0A) are skipped. Any other character except a colon pulses `err` with `err_kind` = 1.
- R9: A non-hex, non-colon character inside a record pulses `err` with `err_kind` = 1 and abandons the record. The next colon starts a fresh record.
- R10: A colon inside a record pulses `err` with `err_kind` = 1 and starts a new record at once.
- R11: A record whose type is not 00, 01 or 04 and whose checksum is correct pulses `err` with `err_kind` = 3 and outputs no bytes.
- R12: A character presented while `in_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe |
| in_char | input | 8 | ASCII character |
| out_valid | output | 1 | Payload byte strobe |
| out_addr | output | 16 | Address of the payload byte |
| out_data | output | 8 | Payload byte |
| eof | output | 1 | One-cycle pulse on a good end-of-file record |
| done | output | 1 | High once end of file has been seen |
| err | output | 1 | One-cycle error pulse |
| err_kind | output | 2 | Error kind while `err` is high: 1 bad character, 2 checksum, 3 type |

## Verification
The main function is tried on several records, each aimed at a different fault:
- The worked data record in upper case exercises nibble order and the address index.
- A lower-case record at a non-zero offset separates case handling from digit handling.
- A record at offset 0xFFFF separates a wrapping address adder from a wider one.
- The same data with its checksum off by one shows that bytes are emitted before the checksum is judged, and that the mismatch is still reported.
- Idle strobes interleaved into a good record confirm that only strobed characters advance the parser.
- Type 04 and unknown-type records separate skipping from rejecting.
- Stray characters, a stray colon and a mid-record letter separate the three resynchronisation paths.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int CHAR_W = 8;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [BYTE_W-1:0] TYPE_DATA = 8'h00;
    localparam logic [BYTE_W-1:0] TYPE_EOF  = 8'h01;
    localparam logic [BYTE_W-1:0] TYPE_EXT  = 8'h04;

    typedef enum logic [2:0] {
        S_IDLE, S_LEN, S_AHI, S_ALO, S_TYP, S_DATA, S_CSUM, S_DONE
    } pstate_e;

    typedef enum logic [1:0] {
        E_NONE = 2'd0, E_CHAR = 2'd1, E_SUM = 2'd2, E_TYPE = 2'd3
    } perr_e;

    typedef struct packed {
        logic       is_hex;
        logic [3:0] nib;
        logic       is_colon;
        logic       is_eol;
    } char_cls_t;

    function automatic char_cls_t classify(input logic [CHAR_W-1:0] c);
        char_cls_t r;
        r.is_hex   = 1'b0;
        r.nib      = 4'h0;
        r.is_colon = (c == 8'h3A);
        r.is_eol   = (c == 8'h0D) || (c == 8'h0A);
        if (c >= 8'h30 && c <= 8'h39) begin
            r.is_hex = 1'b1;
            r.nib    = 4'(c - 8'h30);
        end else if (c >= 8'h41 && c <= 8'h46) begin
            r.is_hex = 1'b1;
            r.nib    = 4'(c - 8'h37);
        end else if (c >= 8'h61 && c <= 8'h66) begin
            r.is_hex = 1'b1;
            r.nib    = 4'(c - 8'h57);
        end
        return r;
    endfunction

endpackage

// File: rtl/hex_char_class.sv
module hex_char_class
    import hexrec_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output char_cls_t         cls
);
    always_comb cls = classify(ch);
endmodule

// File: rtl/hex_byte_pair.sv
module hex_byte_pair
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              nib_vld,
    input  logic [3:0]        nib,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    logic       have_hi;
    logic [3:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_hi <= 1'b0;
            hi_q    <= 4'h0;
        end else if (nib_vld) begin
            have_hi <= ~have_hi;
            if (!have_hi) hi_q <= nib;
        end
    end

    assign byte_vld = nib_vld && have_hi;
    assign byte_val = {hi_q, nib};

    // R2: a completed byte always leaves the pair collector empty
    a_r2_pair_resets: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !clr) |=> !have_hi);
endmodule

// File: rtl/hex_rec_seq.sv
module hex_rec_seq
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_valid,
    input  char_cls_t         cls,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              busy,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BYTE_W-1:0] out_data,
    output logic              eof,
    output logic              done,
    output logic              err,
    output perr_e             err_kind
);
    pstate_e           state;
    logic [BYTE_W-1:0] sum, len, rtype, idx;
    logic [ADDR_W-1:0] base;
    logic [BYTE_W-1:0] sum_nx;

    assign sum_nx = sum + byte_val;
    assign busy   = (state != S_IDLE) && (state != S_DONE);
    assign done   = (state == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            sum       <= '0;
            len       <= '0;
            rtype     <= '0;
            idx       <= '0;
            base      <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
            eof       <= 1'b0;
            err       <= 1'b0;
            err_kind  <= E_NONE;
        end else begin
            out_valid <= 1'b0;
            eof       <= 1'b0;
            err       <= 1'b0;
            err_kind  <= E_NONE;
            if (ch_valid) begin
                case (state)
                    S_DONE: ;
                    S_IDLE: begin
                        if (cls.is_colon) state <= S_LEN;
                        else if (!cls.is_eol) begin
                            err      <= 1'b1;
                            err_kind <= E_CHAR;
                        end
                    end
                    default: begin
                        if (cls.is_colon) begin
                            err      <= 1'b1;
                            err_kind <= E_CHAR;
                            state    <= S_LEN;
                        end else if (!cls.is_hex) begin
                            err      <= 1'b1;
                            err_kind <= E_CHAR;
                            state    <= S_IDLE;
                        end else if (byte_vld) begin
                            case (state)
                                S_LEN: begin
                                    len   <= byte_val;
                                    sum   <= byte_val;
                                    state <= S_AHI;
                                end
                                S_AHI: begin
                                    base[ADDR_W-1:BYTE_W] <= byte_val;
                                    sum   <= sum_nx;
                                    state <= S_ALO;
                                end
                                S_ALO: begin
                                    base[BYTE_W-1:0] <= byte_val;
                                    sum   <= sum_nx;
                                    state <= S_TYP;
                                end
                                S_TYP: begin
                                    rtype <= byte_val;
                                    sum   <= sum_nx;
                                    idx   <= '0;
                                    state <= (len == '0) ? S_CSUM : S_DATA;
                                end
                                S_DATA: begin
                                    if (rtype == TYPE_DATA) begin
                                        out_valid <= 1'b1;
                                        out_data  <= byte_val;
                                        out_addr  <= base + ADDR_W'(idx);
                                    end
                                    sum <= sum_nx;
                                    idx <= idx + 1'b1;
                                    if (idx == len - 1'b1) state <= S_CSUM;
                                end
                                S_CSUM: begin
                                    state <= S_IDLE;
                                    if (sum_nx != '0) begin
                                        err      <= 1'b1;
                                        err_kind <= E_SUM;
                                    end else if (rtype == TYPE_EOF) begin
                                        eof   <= 1'b1;
                                        state <= S_DONE;
                                    end else if (rtype != TYPE_DATA && rtype != TYPE_EXT) begin
                                        err      <= 1'b1;
                                        err_kind <= E_TYPE;
                                    end
                                end
                                default: state <= S_IDLE;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> (!out_valid && !err && !eof));
    a_r7_eof_with_done: assert property (@(posedge clk) disable iff (rst)
        eof |-> done);
    a_r5_err_has_kind: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_kind != E_NONE));
    a_r3_data_not_with_err: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!err && !eof));
    a_r12_idle_strobe_holds: assert property (@(posedge clk) disable iff (rst)
        (!ch_valid && !$past(rst)) |=> $stable(state));
endmodule

// File: rtl/hex_record_parser.sv
module hex_record_parser
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BYTE_W-1:0] out_data,
    output logic              eof,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_kind
);
    char_cls_t         cls;
    logic              busy, byte_vld, nib_vld, pair_clr;
    logic [BYTE_W-1:0] byte_val;
    perr_e             kind;

    hex_char_class u_class (.ch(in_char), .cls(cls));

    assign nib_vld  = in_valid && cls.is_hex && busy;
    assign pair_clr = in_valid && !cls.is_hex;

    hex_byte_pair u_pair (
        .clk(clk), .rst(rst), .clr(pair_clr), .nib_vld(nib_vld), .nib(cls.nib),
        .byte_vld(byte_vld), .byte_val(byte_val)
    );

    hex_rec_seq u_seq (
        .clk(clk), .rst(rst), .ch_valid(in_valid), .cls(cls),
        .byte_vld(byte_vld), .byte_val(byte_val), .busy(busy),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .eof(eof), .done(done), .err(err), .err_kind(kind)
    );

    assign err_kind = kind;
endmodule

// File: tb/test_hex_record_parser.sv
`timescale 1ns/1ps
module test_hex_record_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        out_valid, eof, done, err;
    logic [15:0] out_addr;
    logic [7:0]  out_data;
    logic [1:0]  err_kind;

    int tests = 0, fails = 0;
    int cap_n = 0, err_n = 0, eof_n = 0;
    logic [15:0] cap_addr [0:63];
    logic [7:0]  cap_data [0:63];
    logic [1:0]  last_kind;

    always #5 clk = ~clk;

    hex_record_parser i_hex_record_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .eof(eof), .done(done), .err(err), .err_kind(err_kind)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && cap_n < 64) begin
                cap_addr[cap_n] = out_addr;
                cap_data[cap_n] = out_data;
                cap_n++;
            end
            if (err) begin
                err_n++;
                last_kind = err_kind;
            end
            if (eof) eof_n++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; err_n = 0; eof_n = 0; last_kind = 2'd0;
    endtask

    task automatic send(string s, bit gaps);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = s[i];
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_char  = "Z";
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_char  = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "eof", eof, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
    endtask

    task automatic t_example();
        clear_cap();
        send(":0400000005FA394D77\r\n", 0);
        chk("R3", "count", cap_n, 4);
        chk("R2", "byte0", cap_data[0], 8'h05);
        chk("R2", "byte1", cap_data[1], 8'hFA);
        chk("R3", "byte3", cap_data[3], 8'h4D);
        chk("R3", "addr3", cap_addr[3], 16'h0003);
        chk("R5", "no err", err_n, 0);
    endtask

    task automatic t_lower();
        clear_cap();
        send(":0200040055aafb\n", 0);
        chk("R2", "count", cap_n, 2);
        chk("R2", "byte1", cap_data[1], 8'hAA);
        chk("R3", "addr0", cap_addr[0], 16'h0004);
        chk("R3", "addr1", cap_addr[1], 16'h0005);
        chk("R5", "no err", err_n, 0);
    endtask

    task automatic t_wrap();
        clear_cap();
        send(":02FFFF00AABB9B\r\n", 0);
        chk("R4", "addr0", cap_addr[0], 16'hFFFF);
        chk("R4", "addr1", cap_addr[1], 16'h0000);
        chk("R4", "err", err_n, 0);
    endtask

    task automatic t_badsum();
        clear_cap();
        send(":0400000005FA394D78\r\n", 0);
        chk("R5", "bytes still out", cap_n, 4);
        chk("R5", "err count", err_n, 1);
        chk("R5", "err kind", last_kind, 2);
    endtask

    task automatic t_gaps();
        clear_cap();
        send(":0100100042AD\r\n", 1);
        chk("R12", "count", cap_n, 1);
        chk("R12", "data", cap_data[0], 8'h42);
        chk("R12", "addr", cap_addr[0], 16'h0010);
        chk("R12", "err", err_n, 0);
    endtask

    task automatic t_ext();
        clear_cap();
        send(":020000040000FA\r\n", 0);
        chk("R6", "no bytes", cap_n, 0);
        chk("R6", "no err", err_n, 0);
    endtask

    task automatic t_badtype();
        clear_cap();
        send(":0100000203FA\r\n", 0);
        chk("R11", "no bytes", cap_n, 0);
        chk("R11", "err count", err_n, 1);
        chk("R11", "err kind", last_kind, 3);
    endtask

    task automatic t_junk();
        clear_cap();
        send("\r\n\r\n", 0);
        chk("R8", "eol skipped", err_n, 0);
        send("x\r\n", 0);
        chk("R8", "junk err", err_n, 1);
        chk("R8", "junk kind", last_kind, 1);
    endtask

    task automatic t_nonhex();
        clear_cap();
        send(":04G\r\n:0100100042AD\r\n", 0);
        chk("R9", "err count", err_n, 1);
        chk("R9", "err kind", last_kind, 1);
        chk("R9", "resync count", cap_n, 1);
        chk("R9", "resync data", cap_data[0], 8'h42);
    endtask

    task automatic t_colon();
        clear_cap();
        send(":0400:0100100042AD\r\n", 0);
        chk("R10", "err count", err_n, 1);
        chk("R10", "err kind", last_kind, 1);
        chk("R10", "count", cap_n, 1);
        chk("R10", "addr", cap_addr[0], 16'h0010);
    endtask

    task automatic t_eof();
        clear_cap();
        send(":00000001FF\r\n", 0);
        chk("R7", "eof pulses", eof_n, 1);
        chk("R7", "done", done, 1);
        chk("R7", "err", err_n, 0);
        clear_cap();
        send(":0100100042AD\r\nxyz:00000001FF", 0);
        chk("R7", "bytes after done", cap_n, 0);
        chk("R7", "err after done", err_n, 0);
        chk("R7", "eof after done", eof_n, 0);
        chk("R7", "done held", done, 1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_example();
        t_lower();
        t_wrap();
        t_badsum();
        t_gaps();
        t_ext();
        t_badtype();
        t_junk();
        t_nonhex();
        t_colon();
        t_eof();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule